// File: doc/BRIEF.md
# Windowed Display RAM Address Counter

This block turns a byte stream of commands and parameters into write addresses for a one-bit-per-pixel display memory of 128 by 296 pixels, organised as 16 bytes per row (4736 bytes). Software first sets an inclusive X window in whole bytes and an inclusive Y window in rows. It then places the cursor, issues a write command for one of two pixel planes, and streams data bytes. Each data byte produces one RAM write strobe, with the linear byte address, the plane select and the byte itself. After each data byte the cursor advances: X moves first, and Y moves when X wraps.

The command decoder is a state machine with six states. ST_IDLE ignores data. ST_XWIN takes two X window bytes. ST_YWIN takes four Y window bytes. ST_XCUR takes one X cursor byte. ST_YCUR takes two Y cursor bytes. ST_WRITE turns every data byte into a write. Any command byte moves the machine to the state that the command selects. An unknown command or the soft reset command selects ST_IDLE. When the last parameter byte of a window or cursor command has been taken, the machine returns to ST_IDLE. ST_WRITE is left only by a new command.

A gray-scale input adds a one-byte offset to every X window and X cursor value as it is loaded. This moves the image right by 8 pixels, which gray-scale operation needs.

Top module: `wram_addr_top`

## Requirements
- R1: After the reset pin, the X window is bytes 0..15, the Y window is rows 0..295 and the cursor is (0,0), so the first data byte after command 0x24 writes address 0; ram_we is 0 while no data is streamed.
- R2: Command 0x44 takes two data bytes, the X window start byte then the X window end byte; both bounds are inclusive.
- R3: Command 0x45 takes four data bytes: start row low byte, start row high byte, end row low byte, end row high byte. The 9-bit row value is formed from bit 0 of the high byte above the low byte, and both bounds are inclusive.
- R4: Command 0x4E takes one data byte, the X cursor byte. Command 0x4F takes two data bytes, the Y cursor low byte then the high byte.
- R5: After command 0x24, every data byte is written to plane 0 (ram_plane=0); after command 0x26, to plane 1. ram_we, ram_addr, ram_plane and ram_data are registered and show a data byte in the cycle after the clock edge that accepts it, with ram_data equal to that byte.
- R6: After each data write, X increments unless it equals the X window end. In that case X reloads the X window start and Y steps. Y increments unless it equals the Y window end, in which case it reloads the Y window start.
- R7: The written address is Y×16 + X.
- R8: A write whose X is 16 or more, or whose Y is 296 or more, is suppressed (ram_we stays 0), but the cursor still advances as in R6.
- R9: While gray_mode is 1, every X window and X cursor byte is loaded as its value plus one.
- R10: Data bytes are ignored and leave the cursor unchanged in three cases: no command has selected a parameter or write state, the command's parameter bytes are complete, or the command is unknown.
- R11: Command 0x12 restores the full-screen window and cursor (0,0) of R1 and returns the decoder to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is present on in_byte this cycle |
| in_is_cmd | input | 1 | 1: the byte is a command, 0: a data byte |
| in_byte | input | 8 | Command or data byte |
| gray_mode | input | 1 | Apply the one-byte X offset to X window and X cursor loads |
| ram_we | output | 1 | RAM byte write strobe |
| ram_plane | output | 1 | Plane select, 0 for low plane, 1 for high plane |
| ram_addr | output | 13 | Linear RAM byte address |
| ram_data | output | 8 | Byte to write |

## Verification
Every RAM-side result is due in the cycle after the clock edge that accepts the data byte. The counter update from that byte lands on the same edge, so the following byte already sees the advanced cursor. The bench drives each byte on the falling edge and waits for the next rising edge. It samples 1 ns later, so each check sees exactly the write caused by that byte. Window and cursor loads have no port of their own. Their effect is checked through the address of the next write, and so is the effect of ignored bytes.

// File: rtl/wram_pkg.sv
package wram_pkg;

    localparam logic [7:0] OP_SWRST  = 8'h12;
    localparam logic [7:0] OP_WR_LO  = 8'h24;
    localparam logic [7:0] OP_WR_HI  = 8'h26;
    localparam logic [7:0] OP_XWIN   = 8'h44;
    localparam logic [7:0] OP_YWIN   = 8'h45;
    localparam logic [7:0] OP_XCUR   = 8'h4E;
    localparam logic [7:0] OP_YCUR   = 8'h4F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XWIN,
        ST_YWIN,
        ST_XCUR,
        ST_YCUR,
        ST_WRITE
    } wram_state_e;

endpackage

// File: rtl/wram_axis.sv
module wram_axis #(
    parameter int W       = 8,
    parameter int RST_END = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld_start,
    input  logic         ld_end,
    input  logic         ld_cur,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    output logic [W-1:0] cur,
    output logic         at_end
);

    localparam logic [W-1:0] END_HOME = W'(RST_END);

    logic [W-1:0] start_q, end_q, cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= END_HOME;
            cur_q   <= '0;
        end else if (clr) begin
            start_q <= '0;
            end_q   <= END_HOME;
            cur_q   <= '0;
        end else begin
            if (ld_start) start_q <= ld_val;
            if (ld_end)   end_q   <= ld_val;
            if (ld_cur)   cur_q   <= ld_val;
            else if (step) cur_q  <= (cur_q == end_q) ? start_q : cur_q + 1'b1;
        end
    end

    assign cur    = cur_q;
    assign at_end = (cur_q == end_q);

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_end && !clr && !ld_cur && !ld_start) |=> (cur == $past(start_q))); // R6
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_end && !clr && !ld_cur) |=> (cur == $past(cur) + 1'b1)); // R6
    AST_CLR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cur == '0 && at_end == (END_HOME == '0))); // R11

endmodule

// File: rtl/wram_cmd_fsm.sv
module wram_cmd_fsm
    import wram_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_is_cmd,
    input  logic [7:0]    in_byte,
    input  logic          gray_mode,
    output logic          clr,
    output logic          x_ld_start,
    output logic          x_ld_end,
    output logic          x_ld_cur,
    output logic [XW-1:0] x_val,
    output logic          y_ld_start,
    output logic          y_ld_end,
    output logic          y_ld_cur,
    output logic [YW-1:0] y_val,
    output logic          wr_fire,
    output logic          wr_plane
);

    wram_state_e state_q, state_n;
    logic [1:0]  idx_q, idx_n;
    logic [7:0]  lo_q, lo_n;
    logic        plane_q, plane_n;
    logic        cmd_stb, data_stb;

    assign cmd_stb  = in_valid &  in_is_cmd;
    assign data_stb = in_valid & ~in_is_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            lo_q    <= '0;
            plane_q <= 1'b0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            lo_q    <= lo_n;
            plane_q <= plane_n;
        end
    end

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        lo_n    = lo_q;
        plane_n = plane_q;
        if (cmd_stb) begin
            idx_n = '0;
            case (in_byte)
                OP_XWIN:  state_n = ST_XWIN;
                OP_YWIN:  state_n = ST_YWIN;
                OP_XCUR:  state_n = ST_XCUR;
                OP_YCUR:  state_n = ST_YCUR;
                OP_WR_LO: begin state_n = ST_WRITE; plane_n = 1'b0; end
                OP_WR_HI: begin state_n = ST_WRITE; plane_n = 1'b1; end
                default:  state_n = ST_IDLE;
            endcase
        end else if (data_stb) begin
            lo_n  = in_byte;
            idx_n = idx_q + 2'd1;
            unique case (state_q)
                ST_IDLE:  state_n = ST_IDLE;
                ST_XWIN:  if (idx_q == 2'd1) state_n = ST_IDLE;
                ST_YWIN:  if (idx_q == 2'd3) state_n = ST_IDLE;
                ST_XCUR:  state_n = ST_IDLE;
                ST_YCUR:  if (idx_q == 2'd1) state_n = ST_IDLE;
                ST_WRITE: state_n = ST_WRITE;
            endcase
        end
    end

    always_comb begin
        clr        = cmd_stb && (in_byte == OP_SWRST);
        x_ld_start = 1'b0;
        x_ld_end   = 1'b0;
        x_ld_cur   = 1'b0;
        y_ld_start = 1'b0;
        y_ld_end   = 1'b0;
        y_ld_cur   = 1'b0;
        wr_fire    = 1'b0;
        wr_plane   = plane_q;
        x_val      = gray_mode ? XW'(in_byte) + 1'b1 : XW'(in_byte);
        y_val      = YW'({in_byte, lo_q});
        if (data_stb) begin
            unique case (state_q)
                ST_IDLE:  ;
                ST_XWIN:  begin
                    x_ld_start = (idx_q == 2'd0);
                    x_ld_end   = (idx_q == 2'd1);
                end
                ST_YWIN:  begin
                    y_ld_start = (idx_q == 2'd1);
                    y_ld_end   = (idx_q == 2'd3);
                end
                ST_XCUR:  x_ld_cur = 1'b1;
                ST_YCUR:  y_ld_cur = (idx_q == 2'd1);
                ST_WRITE: wr_fire  = 1'b1;
            endcase
        end
    end

    AST_CUR_ARGS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XCUR && data_stb) |=> (state_q == ST_IDLE)); // R4
    AST_PLANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && !cmd_stb) |=> (state_q == ST_WRITE && $stable(plane_q))); // R5
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(wr_fire || x_ld_cur || y_ld_cur)); // R10

endmodule

// File: rtl/wram_addr_map.sv
module wram_addr_map #(
    parameter int XW   = 8,
    parameter int YW   = 9,
    parameter int AW   = 13,
    parameter int BPR  = 16,
    parameter int ROWS = 296
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic [AW-1:0] lin,
    output logic          in_range
);

    localparam int SW  = XW + YW;
    localparam int BSH = $clog2(BPR);

    logic [SW-1:0] wide;

    generate
        if ((BPR & (BPR - 1)) == 0) begin : g_shift
            assign wide = (SW'(y) << BSH) + SW'(x);
        end else begin : g_mult
            assign wide = SW'(y) * SW'(BPR) + SW'(x);
        end
    endgenerate

    assign lin      = AW'(wide);
    assign in_range = ({1'b0, x} < (XW+1)'(BPR)) && ({1'b0, y} < (YW+1)'(ROWS));

endmodule

// File: rtl/wram_addr_top.sv
module wram_addr_top
    import wram_pkg::*;
#(
    parameter int  WIDTH_PIX = 128,
    parameter int  HEIGHT    = 296,
    localparam int BPR       = WIDTH_PIX / 8,
    localparam int RAM_BYTES = BPR * HEIGHT,
    localparam int AW        = $clog2(RAM_BYTES),
    localparam int YW        = $clog2(HEIGHT),
    localparam int XW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_is_cmd,
    input  logic [7:0]    in_byte,
    input  logic          gray_mode,
    output logic          ram_we,
    output logic          ram_plane,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_data
);

    logic          clr, wr_fire, wr_plane;
    logic          x_ld_start, x_ld_end, x_ld_cur;
    logic          y_ld_start, y_ld_end, y_ld_cur;
    logic [XW-1:0] x_val, x_cur;
    logic [YW-1:0] y_val, y_cur;
    logic          x_at_end, y_at_end;
    logic [AW-1:0] lin;
    logic          in_range;

    wram_cmd_fsm #(.XW(XW), .YW(YW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
        .gray_mode(gray_mode), .clr(clr),
        .x_ld_start(x_ld_start), .x_ld_end(x_ld_end), .x_ld_cur(x_ld_cur), .x_val(x_val),
        .y_ld_start(y_ld_start), .y_ld_end(y_ld_end), .y_ld_cur(y_ld_cur), .y_val(y_val),
        .wr_fire(wr_fire), .wr_plane(wr_plane)
    );

    wram_axis #(.W(XW), .RST_END(BPR - 1)) u_xaxis (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ld_start(x_ld_start), .ld_end(x_ld_end), .ld_cur(x_ld_cur), .ld_val(x_val),
        .step(wr_fire), .cur(x_cur), .at_end(x_at_end)
    );

    wram_axis #(.W(YW), .RST_END(HEIGHT - 1)) u_yaxis (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ld_start(y_ld_start), .ld_end(y_ld_end), .ld_cur(y_ld_cur), .ld_val(y_val),
        .step(wr_fire && x_at_end), .cur(y_cur), .at_end(y_at_end)
    );

    wram_addr_map #(.XW(XW), .YW(YW), .AW(AW), .BPR(BPR), .ROWS(HEIGHT)) u_map (
        .x(x_cur), .y(y_cur), .lin(lin), .in_range(in_range)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_plane <= 1'b0;
            ram_addr  <= '0;
            ram_data  <= '0;
        end else begin
            ram_we <= wr_fire && in_range;
            if (wr_fire) begin
                ram_plane <= wr_plane;
                ram_addr  <= lin;
                ram_data  <= in_byte;
            end
        end
    end

    AST_WE_IN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ({1'b0, ram_addr} < (AW+1)'(RAM_BYTES))); // R8
    AST_WE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(in_valid && !in_is_cmd)); // R5
    AST_Y_HOLDS_MIDROW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !x_at_end && !clr && !y_ld_cur) |=> $stable(y_cur)); // R6
    AST_Y_END_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && x_at_end && !y_at_end && !clr && !y_ld_cur) |=> (y_cur == $past(y_cur) + 1'b1)); // R6

endmodule

// File: tb/test_wram_addr_top.sv
module test_wram_addr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_cmd = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        gray_mode = 1'b0;
    logic        ram_we, ram_plane;
    logic [12:0] ram_addr;
    logic [7:0]  ram_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    wram_addr_top i_wram_addr_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
        .in_byte(in_byte), .gray_mode(gray_mode), .ram_we(ram_we),
        .ram_plane(ram_plane), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    // {is_cmd, byte[7:0], exp_we, exp_plane, exp_addr[12:0]}
    localparam int NV = 21;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 8'h44, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h02, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h03, 1'b0, 1'b0, 13'd0},
        {1'b1, 8'h45, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h05, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h00, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h06, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h00, 1'b0, 1'b0, 13'd0},
        {1'b1, 8'h4E, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h03, 1'b0, 1'b0, 13'd0},
        {1'b1, 8'h4F, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h06, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'h00, 1'b0, 1'b0, 13'd0},
        {1'b1, 8'h24, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'hA1, 1'b1, 1'b0, 13'd99},
        {1'b0, 8'hA2, 1'b1, 1'b0, 13'd82},
        {1'b0, 8'hA3, 1'b1, 1'b0, 13'd83},
        {1'b0, 8'hA4, 1'b1, 1'b0, 13'd98},
        {1'b1, 8'h26, 1'b0, 1'b0, 13'd0},
        {1'b0, 8'hB1, 1'b1, 1'b1, 13'd99},
        {1'b0, 8'hB2, 1'b1, 1'b1, 13'd82}
    };

    task automatic put(input logic c, input logic [7:0] b);
        @(negedge clk);
        in_valid  = 1'b1;
        in_is_cmd = c;
        in_byte   = b;
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_wr(input string tag, input logic ew, input int ea, input logic ep);
        total++;
        if (ram_we !== ew || (ew && (ram_addr !== 13'(ea) || ram_plane !== ep))) begin
            bad++;
            $display("FAIL %s: we=%0b addr=%0d plane=%0b, expected we=%0b addr=%0d plane=%0b",
                     tag, ram_we, ram_addr, ram_plane, ew, ea, ep);
        end
    endtask

    task automatic wr(input string tag, input logic [7:0] b, input logic ew, input int ea, input logic ep);
        put(1'b0, b);
        expect_wr(tag, ew, ea, ep);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected end");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_wr("R1 we low in reset", 1'b0, 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet();
        expect_wr("R1 we low after reset", 1'b0, 0, 1'b0);

        // R1 / R7 home position
        put(1'b1, 8'h24);
        wr("R1 first write at 0", 8'h55, 1'b1, 0, 1'b0);
        total++;
        if (ram_data !== 8'h55) begin
            bad++;
            $display("FAIL R5 data: got %0h expected 55", ram_data);
        end
        wr("R7 next byte", 8'h56, 1'b1, 1, 1'b0);
        put(1'b1, 8'h12);

        // table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            put(VEC[i][23], VEC[i][22:15]);
            expect_wr($sformatf("R2/R3/R4/R6/R7 vec %0d", i), VEC[i][14], int'(VEC[i][12:0]), VEC[i][13]);
            if (VEC[i][14]) begin
                total++;
                if (ram_data !== VEC[i][22:15]) begin
                    bad++;
                    $display("FAIL R5 vec %0d data: got %0h expected %0h", i, ram_data, VEC[i][22:15]);
                end
            end
        end

        // R3 R6 bottom of screen, 9-bit rows and Y wrap
        put(1'b1, 8'h12);
        put(1'b1, 8'h4F); put(1'b0, 8'h26); put(1'b0, 8'h01);
        put(1'b1, 8'h4E); put(1'b0, 8'h0F);
        put(1'b1, 8'h24);
        wr("R3 row 294 x15", 8'h01, 1'b1, 4719, 1'b0);
        wr("R6 x wrap row 295", 8'h02, 1'b1, 4720, 1'b0);
        put(1'b1, 8'h4E); put(1'b0, 8'h0F);
        put(1'b1, 8'h24);
        wr("R7 last byte", 8'h03, 1'b1, 4735, 1'b0);
        wr("R6 y wrap to start", 8'h04, 1'b1, 0, 1'b0);

        // R8 suppression with advance
        put(1'b1, 8'h12);
        put(1'b1, 8'h44); put(1'b0, 8'h00); put(1'b0, 8'h10);
        put(1'b1, 8'h4E); put(1'b0, 8'h0F);
        put(1'b1, 8'h26);
        wr("R8 in range", 8'h11, 1'b1, 15, 1'b1);
        wr("R8 x16 suppressed", 8'h12, 1'b0, 0, 1'b1);
        wr("R8 advanced past", 8'h13, 1'b1, 16, 1'b1);

        // R9 gray offset
        gray_mode = 1'b1;
        put(1'b1, 8'h12);
        put(1'b1, 8'h44); put(1'b0, 8'h00); put(1'b0, 8'h01);
        put(1'b1, 8'h4E); put(1'b0, 8'h01);
        put(1'b1, 8'h24);
        wr("R9 shifted cursor", 8'h21, 1'b1, 2, 1'b0);
        wr("R9 shifted window", 8'h22, 1'b1, 17, 1'b0);
        gray_mode = 1'b0;

        // R10 ignored data
        put(1'b1, 8'h12);
        wr("R10 idle data", 8'h31, 1'b0, 0, 1'b0);
        put(1'b1, 8'h4E); put(1'b0, 8'h05);
        wr("R10 extra arg", 8'h09, 1'b0, 0, 1'b0);
        put(1'b1, 8'h99);
        wr("R10 unknown cmd data", 8'h07, 1'b0, 0, 1'b0);
        put(1'b1, 8'h24);
        wr("R10 cursor unchanged", 8'h32, 1'b1, 5, 1'b0);

        // R11 soft reset
        put(1'b1, 8'h44); put(1'b0, 8'h04); put(1'b0, 8'h05);
        put(1'b1, 8'h45); put(1'b0, 8'h03); put(1'b0, 8'h00); put(1'b0, 8'h03); put(1'b0, 8'h00);
        put(1'b1, 8'h4E); put(1'b0, 8'h05);
        put(1'b1, 8'h4F); put(1'b0, 8'h03); put(1'b0, 8'h00);
        put(1'b1, 8'h12);
        wr("R11 data after soft reset idle", 8'h40, 1'b0, 0, 1'b0);
        put(1'b1, 8'h24);
        wr("R11 home", 8'h41, 1'b1, 0, 1'b0);
        wr("R11 full window", 8'h42, 1'b1, 1, 1'b0);

        // R1 reset pin again
        quiet();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        expect_wr("R1 we cleared", 1'b0, 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        put(1'b1, 8'h24);
        wr("R1 home after reset", 8'h50, 1'b1, 0, 1'b0);
        quiet();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule